// File: doc/BRIEF.md
# Lockable Clock Routing Register File

This block holds one clock-control entry for each peripheral clock channel. An entry holds three things: a 4-bit generator selection, a clock enable and a write lock. Software reaches an entry indirectly through a 6-bit channel ID. It writes a word whose ID field picks the entry, then reads back a packed word for the entry that is currently selected. The generator selection and the enable of every channel come out as registered outputs, and downstream clock muxing and gating logic uses them.

There are two synchronous, active-low resets, and each restores a different subset of the state:

- **Power reset.** It restores every entry. The watchdog channel (ID 1) starts from two non-volatile configuration bits.
- **User reset.** It respects the lock bits and leaves every lock unchanged. The real-time-clock channel (ID 2) keeps its settings while it is enabled. The watchdog channel reloads its defaults.
- **Both at once.** The power reset wins.

IDs 0 to 27 are real channels, and IDs 28 to 63 are reserved.

Top module: `clk_route_regs`

## Requirements
- R1: While `por_n` is low at a clock edge, every entry becomes generator 0, enable 0, lock 0. The exception is the watchdog entry (ID 1), which becomes generator 2, enable = `nv_wdt_en` and lock = `nv_wdt_aon`. The select pointer also returns to 0.
- R2: When `usr_rst_n` is low (and `por_n` high) at an edge, an ordinary channel with lock 0 clears its generator and enable to 0. With lock 1 it is unchanged.
- R3: On a user reset, the real-time-clock entry (ID 2) clears its generator and enable only if both its lock and its enable are 0. Otherwise it keeps its state.
- R4: On a user reset, the watchdog entry with lock 0 returns to generator 2 and takes enable from `nv_wdt_en`. With lock 1 it is unchanged.
- R5: A user reset never changes a lock bit, and it returns the select pointer to 0.
- R6: A write (`cfg_we` high) to a valid, unlocked ID stores the generator, enable and lock taken from `wr_data` at that edge. The `ch_gen` and `ch_en` outputs show the new values right after that edge.
- R7: A write to an entry whose lock is 1 is ignored, and this includes its lock bit.
- R8: A write to ID 28..63 changes no entry. While a reserved ID is selected, `rd_data` shows the ID with all other fields 0.
- R9: The word format is the same for writes and reads:
  - ID in bits [5:0];
  - generator in bits [11:8];
  - enable in bit 14;
  - lock in bit 15;
  - other bits read 0.

  `sel_we` or `cfg_we` loads the select pointer from `wr_data[5:0]`. `rd_data` shows the selected entry right after that edge.
- R10: If both resets are low at the same edge, the result is the power-reset result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, synchronous, active low |
| usr_rst_n | input | 1 | User reset, synchronous, active low |
| nv_wdt_en | input | 1 | Non-volatile watchdog enable default |
| nv_wdt_aon | input | 1 | Non-volatile watchdog always-on (lock default) |
| sel_we | input | 1 | Load the select pointer only |
| cfg_we | input | 1 | Write the entry named in `wr_data` and select it |
| wr_data | input | 16 | Write word (ID, generator, enable, lock) |
| rd_data | output | 16 | Packed word for the selected entry |
| ch_en | output | 28 | Per-channel clock enable |
| ch_gen | output | 112 | Per-channel generator selection, 4 bits per channel |

## Verification
A wrong entry shows on `ch_en` or `ch_gen` in the cycle right after the edge that corrupted it, because those outputs are the entry registers themselves. A wrong lock bit stays hidden until either the entry is selected on `rd_data`, or a later write or user reset is wrongly accepted or refused. The stimulus therefore follows every lock change with a write or a user reset that the lock must block or allow. The reference model is compared with all channels on every clock, so a fault shows within one cycle of the point where an output could reveal it.

// File: rtl/clkrt_pkg.sv
// Shared definitions for the clock routing register file.
// Assumes a 16-bit access word with fixed field positions.
package clkrt_pkg;
    typedef enum logic [1:0] {
        KIND_PLAIN = 2'd0,
        KIND_RTC   = 2'd1,
        KIND_WDT   = 2'd2
    } ch_kind_e;

    localparam int WORD_W   = 16;
    localparam int ID_W     = 6;
    localparam int GEN_W    = 4;
    localparam int GEN_LSB  = 8;
    localparam int EN_BIT   = 14;
    localparam int LOCK_BIT = 15;

    // Picks the reset behaviour of a channel from its index.
    function automatic ch_kind_e kind_of(input int idx, input int rtc_id, input int wdt_id);
        if (idx == rtc_id) return KIND_RTC;
        if (idx == wdt_id) return KIND_WDT;
        return KIND_PLAIN;
    endfunction
endpackage

// File: rtl/clkrt_wr_decode.sv
// Turns a write strobe and a channel ID into one write enable per channel.
// Assumes: IDs at or above NUM_CH match no channel, so those writes are dropped.
module clkrt_wr_decode #(
    parameter int NUM_CH = 28,
    parameter int ID_W   = 6
) (
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   id,
    output logic [NUM_CH-1:0] we_vec
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        // One comparator per channel.
        assign we_vec[i] = cfg_we && (id == ID_W'(i));
    end

    // R8
    always_comb begin
        reserved_no_we_chk: assert (!(cfg_we && id >= ID_W'(NUM_CH)) || we_vec == '0);
    end
endmodule

// File: rtl/clkrt_entry.sv
// One clock-control entry: generator selection, enable and write lock.
// KIND chooses the reset behaviour:
//   plain - clears when unlocked;
//   RTC   - survives a user reset while enabled;
//   WDT   - takes its defaults from the non-volatile bits.
// Assumes: synchronous active-low resets, and the power reset has priority.
module clkrt_entry #(
    parameter clkrt_pkg::ch_kind_e KIND    = clkrt_pkg::KIND_PLAIN,
    parameter int                  GEN_W   = 4,
    parameter logic [GEN_W-1:0]    WDT_GEN = GEN_W'(2)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             usr_n,
    input  logic             nv_en,
    input  logic             nv_aon,
    input  logic             we,
    input  logic [GEN_W-1:0] wr_gen,
    input  logic             wr_en,
    input  logic             wr_lock,
    output logic [GEN_W-1:0] gen,
    output logic             en,
    output logic             lock
);
    import clkrt_pkg::*;

    localparam bit IS_WDT = (KIND == KIND_WDT);
    localparam bit IS_RTC = (KIND == KIND_RTC);

    logic unused_nv;
    assign unused_nv = nv_en ^ nv_aon;

    // Entry state update: power reset, then user reset, then an unlocked write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            gen  <= IS_WDT ? WDT_GEN : '0;
            en   <= IS_WDT ? nv_en : 1'b0;
            lock <= IS_WDT ? nv_aon : 1'b0;
        end else if (!usr_n) begin
            if (!lock) begin
                if (IS_WDT) begin
                    gen <= WDT_GEN;
                    en  <= nv_en;
                end else if (IS_RTC) begin
                    if (!en) gen <= '0;
                end else begin
                    gen <= '0;
                    en  <= 1'b0;
                end
            end
        end else if (we && !lock) begin
            gen  <= wr_gen;
            en   <= wr_en;
            lock <= wr_lock;
        end
    end

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        lock |=> lock);

    // R7
    locked_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
        lock |=> ($stable(gen) && $stable(en)));

    if (IS_RTC) begin : g_rtc_chk
        // R3
        rtc_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
            (!usr_n && en) |=> en);
    end else if (IS_WDT) begin : g_wdt_chk
        // R4
        wdt_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
            (!usr_n && !lock) |=> (gen == WDT_GEN && en == $past(nv_en)));
    end else begin : g_plain_chk
        // R2
        plain_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
            (!usr_n && !lock) |=> (gen == '0 && !en));
    end
endmodule

// File: rtl/clkrt_rd_mux.sv
// Builds the packed read word for the selected channel.
// Assumes: a reserved pointer returns only its ID, with all other fields zero.
module clkrt_rd_mux #(
    parameter int NUM_CH = 28,
    parameter int ID_W   = 6,
    parameter int GEN_W  = 4
) (
    input  logic [ID_W-1:0]         ptr,
    input  logic [NUM_CH*GEN_W-1:0] gen_flat,
    input  logic [NUM_CH-1:0]       en_vec,
    input  logic [NUM_CH-1:0]       lock_vec,
    output logic [15:0]             rd_data
);
    import clkrt_pkg::*;

    logic [GEN_W-1:0] sel_gen;
    logic             sel_en;
    logic             sel_lock;

    // Selects the fields of the channel that the pointer names.
    always_comb begin
        sel_gen  = '0;
        sel_en   = 1'b0;
        sel_lock = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ptr == ID_W'(i)) begin
                sel_gen  = gen_flat[i*GEN_W +: GEN_W];
                sel_en   = en_vec[i];
                sel_lock = lock_vec[i];
            end
        end
    end

    // Packs the fields into the access word.
    always_comb begin
        rd_data                           = '0;
        rd_data[ID_W-1:0]                 = ptr;
        rd_data[GEN_LSB +: GEN_W]         = sel_gen;
        rd_data[EN_BIT]                   = sel_en;
        rd_data[LOCK_BIT]                 = sel_lock;
    end

    // R8
    always_comb begin
        reserved_read_chk: assert (ptr < ID_W'(NUM_CH) || rd_data[15:ID_W] == '0);
    end
endmodule

// File: rtl/clk_route_regs.sv
// Top level of the lockable clock routing register file.
// Holds NUM_CH entries that are reached through a select pointer.
// Assumes: GEN_W matches the 4-bit generator field of the access word, and NUM_CH fits in ID_W bits.
module clk_route_regs #(
    parameter int NUM_CH  = 28,
    parameter int RTC_ID  = 2,
    parameter int WDT_ID  = 1,
    parameter int WDT_GEN = 2
) (
    input  logic                                clk,
    input  logic                                por_n,
    input  logic                                usr_rst_n,
    input  logic                                nv_wdt_en,
    input  logic                                nv_wdt_aon,
    input  logic                                sel_we,
    input  logic                                cfg_we,
    input  logic [15:0]                         wr_data,
    output logic [15:0]                         rd_data,
    output logic [NUM_CH-1:0]                   ch_en,
    output logic [NUM_CH*clkrt_pkg::GEN_W-1:0]  ch_gen
);
    import clkrt_pkg::*;

    logic [ID_W-1:0]   ptr;
    logic [ID_W-1:0]   wr_id;
    logic [GEN_W-1:0]  wr_gen;
    logic              wr_en;
    logic              wr_lock;
    logic [NUM_CH-1:0] we_vec;
    logic [NUM_CH-1:0] lock_vec;
    logic              unused_bits;

    assign wr_id       = wr_data[ID_W-1:0];
    assign wr_gen      = wr_data[GEN_LSB +: GEN_W];
    assign wr_en       = wr_data[EN_BIT];
    assign wr_lock     = wr_data[LOCK_BIT];
    assign unused_bits = ^{wr_data[GEN_LSB-1:ID_W], wr_data[EN_BIT-1:GEN_LSB+GEN_W]};

    // Select pointer: cleared by either reset, loaded by any access.
    always_ff @(posedge clk) begin
        if (!por_n || !usr_rst_n) ptr <= '0;
        else if (sel_we || cfg_we) ptr <= wr_id;
    end

    clkrt_wr_decode #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_dec (
        .cfg_we (cfg_we),
        .id     (wr_id),
        .we_vec (we_vec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        clkrt_entry #(
            .KIND    (kind_of(i, RTC_ID, WDT_ID)),
            .GEN_W   (GEN_W),
            .WDT_GEN (GEN_W'(WDT_GEN))
        ) u_entry (
            .clk     (clk),
            .por_n   (por_n),
            .usr_n   (usr_rst_n),
            .nv_en   (nv_wdt_en),
            .nv_aon  (nv_wdt_aon),
            .we      (we_vec[i]),
            .wr_gen  (wr_gen),
            .wr_en   (wr_en),
            .wr_lock (wr_lock),
            .gen     (ch_gen[i*GEN_W +: GEN_W]),
            .en      (ch_en[i]),
            .lock    (lock_vec[i])
        );
    end

    clkrt_rd_mux #(.NUM_CH(NUM_CH), .ID_W(ID_W), .GEN_W(GEN_W)) u_rd (
        .ptr      (ptr),
        .gen_flat (ch_gen),
        .en_vec   (ch_en),
        .lock_vec (lock_vec),
        .rd_data  (rd_data)
    );

    // R8
    reserved_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_we && usr_rst_n && wr_id >= ID_W'(NUM_CH)) |=> ($stable(ch_en) && $stable(ch_gen)));

    // R9
    ptr_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        (usr_rst_n && (sel_we || cfg_we)) |=> (rd_data[ID_W-1:0] == $past(wr_id)));
endmodule

// File: tb/clk_route_regs_test.sv
module clk_route_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 28;

    logic clk = 1'b0;
    logic por_n = 1'b0, usr_rst_n = 1'b1;
    logic nv_wdt_en = 1'b1, nv_wdt_aon = 1'b0;
    logic sel_we = 1'b0, cfg_we = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [N-1:0] ch_en;
    logic [N*4-1:0] ch_gen;

    int total = 0, fails = 0;
    string cur_req = "R1";

    int m_gen[N];
    bit m_en[N], m_lock[N];
    int m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_route_regs uut (
        .clk(clk), .por_n(por_n), .usr_rst_n(usr_rst_n),
        .nv_wdt_en(nv_wdt_en), .nv_wdt_aon(nv_wdt_aon),
        .sel_we(sel_we), .cfg_we(cfg_we), .wr_data(wr_data),
        .rd_data(rd_data), .ch_en(ch_en), .ch_gen(ch_gen)
    );

    task automatic model_step();
        int id;
        id = int'(wr_data[5:0]);
        if (!por_n) begin
            for (int i = 0; i < N; i++) begin m_gen[i] = 0; m_en[i] = 0; m_lock[i] = 0; end
            m_gen[1] = 2; m_en[1] = nv_wdt_en; m_lock[1] = nv_wdt_aon; m_ptr = 0;
        end else if (!usr_rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (m_lock[i]) continue;
                if (i == 1) begin m_gen[i] = 2; m_en[i] = nv_wdt_en; end
                else if (i == 2) begin if (!m_en[i]) m_gen[i] = 0; end
                else begin m_gen[i] = 0; m_en[i] = 0; end
            end
            m_ptr = 0;
        end else begin
            if (cfg_we && id < N && !m_lock[id]) begin
                m_gen[id] = int'(wr_data[11:8]); m_en[id] = wr_data[14]; m_lock[id] = wr_data[15];
            end
            if (sel_we || cfg_we) m_ptr = id;
        end
    endtask

    task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [N-1:0] xe;
        logic [N*4-1:0] xg;
        logic [15:0] xr;
        for (int i = 0; i < N; i++) begin xe[i] = m_en[i]; xg[i*4 +: 4] = 4'(m_gen[i]); end
        xr = 16'(m_ptr);
        if (m_ptr < N) begin xr[11:8] = 4'(m_gen[m_ptr]); xr[14] = m_en[m_ptr]; xr[15] = m_lock[m_ptr]; end
        total++;
        if (ch_en !== xe) begin fails++; $display("FAIL %s ch_en: actual %h expected %h", cur_req, ch_en, xe); end
        total++;
        if (ch_gen !== xg) begin fails++; $display("FAIL %s ch_gen: actual %h expected %h", cur_req, ch_gen, xg); end
        check16(cur_req, rd_data, xr);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic wr(int id, int gen, bit en, bit lock);
        wr_data = {lock, en, 2'b00, 4'(gen), 2'b00, 6'(id)};
        cfg_we = 1'b1; tick(); cfg_we = 1'b0;
    endtask

    task automatic sel(int id);
        wr_data = 16'(id); sel_we = 1'b1; tick(); sel_we = 1'b0;
    endtask

    task automatic ureset();
        usr_rst_n = 1'b0; tick(); usr_rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1: power reset with watchdog enable 1, always-on 0
        cur_req = "R1";
        tick(); tick(); por_n = 1'b1; tick();
        sel(1);
        check16("R1", rd_data, 16'h4201);

        // R6: unlocked writes land one edge later
        cur_req = "R6";
        wr(0, 5, 1, 0); wr(2, 3, 1, 0); wr(5, 7, 1, 0); wr(27, 15, 1, 0);
        check16("R6", {12'h0, ch_gen[27*4 +: 4]}, 16'h000F);

        // R9: read format of the selected entry
        cur_req = "R9";
        sel(5);
        check16("R9", rd_data, 16'h4705);

        // R7: lock, then an ignored write
        cur_req = "R7";
        wr(5, 7, 1, 1); wr(5, 1, 0, 0); sel(5);
        check16("R7", rd_data, 16'hC705);

        // R8: reserved IDs
        cur_req = "R8";
        wr(28, 9, 1, 0); wr(63, 9, 1, 1); sel(40);
        check16("R8", rd_data, 16'h0028);

        // R2 / R3 / R4 / R5: user reset with mixed lock and enable states
        cur_req = "R2";
        wr(1, 6, 0, 0);
        ureset();
        check16("R2", {15'h0, ch_en[0]}, 16'h0000);
        check16("R3", {12'h0, ch_gen[2*4 +: 4]}, 16'h0003);
        cur_req = "R5";
        sel(5);
        check16("R5", rd_data, 16'hC705);
        cur_req = "R4";
        nv_wdt_en = 1'b0; ureset(); sel(1);
        check16("R4", rd_data, 16'h0201);

        // R3: RTC clears only when disabled and unlocked
        cur_req = "R3";
        wr(2, 3, 0, 0); ureset();
        check16("R3", {12'h0, ch_gen[2*4 +: 4]}, 16'h0000);
        wr(2, 4, 0, 1); ureset(); sel(2);
        check16("R3", rd_data, 16'h8402);

        // R4: locked watchdog survives a user reset
        cur_req = "R4";
        wr(1, 9, 1, 1); nv_wdt_en = 1'b1; ureset(); sel(1);
        check16("R4", rd_data, 16'hC901);

        // R10: both resets together, power reset wins
        cur_req = "R10";
        nv_wdt_en = 1'b0; nv_wdt_aon = 1'b1;
        por_n = 1'b0; usr_rst_n = 1'b0; tick();
        por_n = 1'b1; usr_rst_n = 1'b1;
        sel(1);
        check16("R10", rd_data, 16'h8201);
        wr(5, 2, 1, 0);
        check16("R10", {15'h0, ch_en[5]}, 16'h0001);
        wr(1, 3, 1, 0); sel(1);
        check16("R10", rd_data, 16'h8201);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule